// File: doc/BRIEF.md
# Three-wire serial configuration write port

This block lets a host load a small bank of 8-bit configuration registers over three wires: an active-low select (`cs_n`), a serial clock (`sclk`) and a serial data line (`sdi`). Each transfer is a 16-bit write frame. The block samples the three wires in the system clock domain and finds rising `sclk` edges by oversampling. It shifts the frame in and checks its fixed header. On the sixteenth rising edge it commits the data byte to the addressed register.

Writes are blocked while the power-down input is low, and also while the monitored master clock has stopped toggling. Power-down also returns every register to its default value. Register 0 is the control register. It carries a run bit, whose cleared state holds the downstream timing logic in reset but leaves the register contents alone. It also carries a wiring-mode bit and a source-select bit, and these two pick which of two input sources the downstream datapath should use.

Top module: `sercfg_wr_slave`

## Requirements
- R1: A frame is 16 bits, most significant bit first: bits 15:14 are the code 01, bit 13 is the write flag 1, bits 12:8 are the register address and bits 7:0 are the data. A valid frame stores its data byte in the addressed register, and register n appears on `cfg_o[8n+7:8n]`.
- R2: `sdi` is taken on each rising edge of `sclk` while `cs_n` is low. Falling edges shift nothing.
- R3: The commit happens on the 16th rising `sclk` edge after `cs_n` falls. If `cs_n` rises before 16 edges, the frame is dropped and no register changes.
- R4: Once 16 edges have been seen, further `sclk` edges are ignored until `cs_n` goes high. The register keeps the data of the first 16 bits.
- R5: A frame whose top three bits are anything other than 011 changes no register.
- R6: A frame addressed at or above NREG changes no register.
- R7: After `rst` or while `pdn_n` is low, every register holds its default (register 0 = 0x01, all others 0x00). Frames sent while `pdn_n` is low are not stored.
- R8: If `mclk` has not toggled for MCLK_TIMEOUT system clocks, frames are not stored. Writes are accepted again once `mclk` toggles.
- R9: `timing_rst_o` is high exactly when register 0 bit 0 (the run bit) is 0. Changing this bit does not change any other register.
- R10: `mode_3w_o` follows register 0 bit 1. `use_src2_o` is high only when register 0 bit 1 and register 0 bit 2 are both 1, so with bit 1 clear source 1 is always used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pdn_n | input | 1 | Power-down, active low; restores defaults and blocks writes |
| mclk | input | 1 | Master clock being monitored for activity |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock, data taken on rising edge |
| sdi | input | 1 | Serial data in |
| cfg_o | output | NREG*8 | Flattened register bank, register n at bits 8n+7:8n |
| timing_rst_o | output | 1 | Soft reset for downstream timing logic (run bit clear) |
| mode_3w_o | output | 1 | Wiring-mode bit, 1 = three-wire mode |
| use_src2_o | output | 1 | Selects input source 2 for the datapath |

## Verification
A wrong bit count or a wrong header check shows up on `cfg_o` at the end of the frame. Either a register that should have changed keeps its old value, or one that should have stayed put takes a shifted or truncated byte. Every frame is followed by a comparison of the whole bank, so a stray write to any register is caught within one frame. A wrong inhibit or power-down path shows up in the first frame sent under that condition. A wrong control-bit decode shows on `timing_rst_o`, `mode_3w_o` or `use_src2_o` a few system clocks after register 0 is written.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;
  localparam int FRAME_BITS = 16;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam logic [2:0] HDR_WRITE = 3'b011;
  localparam int HDR_MSB    = 15;
  localparam int HDR_LSB    = 13;
  localparam int ADDR_MSB   = 12;
  localparam int ADDR_LSB   = 8;
  localparam int ADDR_W     = ADDR_MSB - ADDR_LSB + 1;
  localparam int DATA_W     = 8;
  localparam int CTRL_ADDR  = 0;
  localparam int RUN_BIT    = 0;
  localparam int MODE_BIT   = 1;
  localparam int SEL_BIT    = 2;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wr_req_t;
endpackage

// File: rtl/sercfg_sync.sv
module sercfg_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        chain <= {chain[STAGES-2:0], d_i[b]};
      end
      assign q_o[b] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/sercfg_frame_rx.sv
module sercfg_frame_rx
  import sercfg_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    cs_n_s,
  input  logic    sclk_s,
  input  logic    sdi_s,
  output logic    wr_en_o,
  output wr_req_t wr_req_o
);
  logic                  sclk_d;
  logic                  sclk_rise;
  logic [CNT_W-1:0]      bit_cnt;
  logic [FRAME_BITS-2:0] shreg;
  logic [FRAME_BITS-1:0] frame_next;

  assign sclk_rise  = sclk_s & ~sclk_d;
  assign frame_next = {shreg, sdi_s};

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= sclk_s;
  end

  // bit counter saturates at FRAME_BITS until select returns high
  always_ff @(posedge clk) begin
    if (rst || cs_n_s) begin
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (sclk_rise && bit_cnt != CNT_W'(FRAME_BITS)) begin
      bit_cnt <= bit_cnt + 1'b1;
      shreg   <= frame_next[FRAME_BITS-2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en_o  <= 1'b0;
      wr_req_o <= '0;
    end else begin
      wr_en_o <= sclk_rise && !cs_n_s
                 && bit_cnt == CNT_W'(FRAME_BITS - 1)
                 && frame_next[HDR_MSB:HDR_LSB] == HDR_WRITE;
      wr_req_o.addr <= frame_next[ADDR_MSB:ADDR_LSB];
      wr_req_o.data <= frame_next[DATA_W-1:0];
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CNT_W'(FRAME_BITS)); // R4
  AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |=> !wr_en_o); // R3
  AST_SELECT_ABORTS: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> !wr_en_o); // R3
endmodule

// File: rtl/sercfg_mclk_mon.sv
module sercfg_mclk_mon #(
  parameter int TIMEOUT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic mclk_s,
  output logic mclk_ok_o
);
  localparam int CW = $clog2(TIMEOUT + 1);

  logic          mclk_d;
  logic          toggle;
  logic [CW-1:0] idle_cnt;

  assign toggle = mclk_s ^ mclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      mclk_d    <= 1'b0;
      idle_cnt  <= CW'(TIMEOUT);
      mclk_ok_o <= 1'b0;
    end else begin
      mclk_d <= mclk_s;
      if (toggle) begin
        idle_cnt  <= '0;
        mclk_ok_o <= 1'b1;
      end else if (idle_cnt != CW'(TIMEOUT)) begin
        idle_cnt <= idle_cnt + 1'b1;
        if (idle_cnt == CW'(TIMEOUT - 1)) mclk_ok_o <= 1'b0;
      end
    end
  end

  AST_SILENCE_DROPS_OK: assert property (@(posedge clk) disable iff (rst)
    (idle_cnt == CW'(TIMEOUT)) |-> !mclk_ok_o); // R8
endmodule

// File: rtl/sercfg_regbank.sv
module sercfg_regbank
  import sercfg_pkg::*;
#(
  parameter int               NREG     = 8,
  parameter logic [NREG*8-1:0] DEFAULTS = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pdn_n_s,
  input  logic              mclk_ok,
  input  logic              wr_en,
  input  wr_req_t           wr_req,
  output logic [NREG*8-1:0] cfg_o,
  output logic              timing_rst_o,
  output logic              mode_3w_o,
  output logic              use_src2_o
);
  logic [DATA_W-1:0] bank [NREG];
  logic              addr_hit;
  logic              commit;

  assign addr_hit = int'(wr_req.addr) < NREG;
  assign commit   = wr_en && addr_hit && mclk_ok && pdn_n_s;

  genvar r;
  generate
    for (r = 0; r < NREG; r++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst || !pdn_n_s)
          bank[r] <= DEFAULTS[r*8 +: 8];
        else if (commit && int'(wr_req.addr) == r)
          bank[r] <= wr_req.data;
      end
      assign cfg_o[r*8 +: 8] = bank[r];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      timing_rst_o <= ~DEFAULTS[CTRL_ADDR*8 + RUN_BIT];
      mode_3w_o    <= DEFAULTS[CTRL_ADDR*8 + MODE_BIT];
      use_src2_o   <= DEFAULTS[CTRL_ADDR*8 + MODE_BIT] & DEFAULTS[CTRL_ADDR*8 + SEL_BIT];
    end else begin
      timing_rst_o <= ~bank[CTRL_ADDR][RUN_BIT];
      mode_3w_o    <= bank[CTRL_ADDR][MODE_BIT];
      use_src2_o   <= bank[CTRL_ADDR][MODE_BIT] & bank[CTRL_ADDR][SEL_BIT];
    end
  end

  AST_PDN_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
    !pdn_n_s |=> cfg_o == DEFAULTS); // R7
  AST_INHIBIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (pdn_n_s && !mclk_ok) |=> $stable(cfg_o)); // R8
  AST_SRC1_IN_4WIRE: assert property (@(posedge clk) disable iff (rst)
    !mode_3w_o |-> !use_src2_o); // R10
endmodule

// File: rtl/sercfg_wr_slave.sv
module sercfg_wr_slave
  import sercfg_pkg::*;
#(
  parameter int             NREG          = 8,
  parameter int             MCLK_TIMEOUT  = 64,
  parameter int             SYNC_STAGES   = 2,
  parameter logic [255:0]   REG_DEFAULTS  = 256'h01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pdn_n,
  input  logic              mclk,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic [NREG*8-1:0] cfg_o,
  output logic              timing_rst_o,
  output logic              mode_3w_o,
  output logic              use_src2_o
);
  localparam int NSYNC = 5;
  localparam logic [NREG*8-1:0] DEFS = REG_DEFAULTS[NREG*8-1:0];

  logic [NSYNC-1:0] raw_in, syn;
  logic             wr_en;
  wr_req_t          wr_req;
  logic             mclk_ok;

  assign raw_in = {pdn_n, mclk, cs_n, sclk, sdi};

  sercfg_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .d_i (raw_in),
    .q_o (syn)
  );

  sercfg_frame_rx i_rx (
    .clk      (clk),
    .rst      (rst),
    .cs_n_s   (syn[2]),
    .sclk_s   (syn[1]),
    .sdi_s    (syn[0]),
    .wr_en_o  (wr_en),
    .wr_req_o (wr_req)
  );

  sercfg_mclk_mon #(.TIMEOUT(MCLK_TIMEOUT)) i_mon (
    .clk       (clk),
    .rst       (rst),
    .mclk_s    (syn[3]),
    .mclk_ok_o (mclk_ok)
  );

  sercfg_regbank #(.NREG(NREG), .DEFAULTS(DEFS)) i_bank (
    .clk          (clk),
    .rst          (rst),
    .pdn_n_s      (syn[4]),
    .mclk_ok      (mclk_ok),
    .wr_en        (wr_en),
    .wr_req       (wr_req),
    .cfg_o        (cfg_o),
    .timing_rst_o (timing_rst_o),
    .mode_3w_o    (mode_3w_o),
    .use_src2_o   (use_src2_o)
  );
endmodule

// File: tb/test_sercfg_wr_slave.sv
module test_sercfg_wr_slave;
  localparam int NREG = 8;
  localparam int HALF = 8;

  logic clk = 1'b0, rst = 1'b1, pdn_n = 1'b1, mclk = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic mclk_en = 1'b1;
  logic [NREG*8-1:0] cfg_o;
  logic timing_rst_o, mode_3w_o, use_src2_o;

  int n_chk = 0, n_bad = 0;
  logic [7:0] mdl [NREG];

  sercfg_wr_slave #(.NREG(NREG), .MCLK_TIMEOUT(64)) i_sercfg_wr_slave (
    .clk(clk), .rst(rst), .pdn_n(pdn_n), .mclk(mclk), .cs_n(cs_n),
    .sclk(sclk), .sdi(sdi), .cfg_o(cfg_o), .timing_rst_o(timing_rst_o),
    .mode_3w_o(mode_3w_o), .use_src2_o(use_src2_o)
  );

  always #5 clk = ~clk;

  initial begin : mclk_gen
    forever begin
      repeat (3) @(negedge clk);
      if (mclk_en) mclk = ~mclk;
    end
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  function automatic logic [15:0] mk(input logic [2:0] hdr, input logic [4:0] a,
                                     input logic [7:0] d);
    return {hdr, a, d};
  endfunction

  task automatic reset_model();
    for (int i = 0; i < NREG; i++) mdl[i] = (i == 0) ? 8'h01 : 8'h00;
  endtask

  // nclk rising edges; bits past the 16th are driven as 1
  task automatic send(input logic [15:0] f, input int nclk);
    @(negedge clk); cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nclk; i++) begin
      sdi = (i < 16) ? f[15-i] : 1'b1;
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    sclk = 1'b0;
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic check_bank(input string req);
    logic [NREG*8-1:0] exp_v;
    for (int i = 0; i < NREG; i++) exp_v[i*8 +: 8] = mdl[i];
    n_chk++;
    if (cfg_o !== exp_v) begin
      n_bad++;
      $display("FAIL %s: cfg_o actual=%h expected=%h", req, cfg_o, exp_v);
    end
  endtask

  task automatic check_ctrl(input string req);
    logic er, em, es;
    er = ~mdl[0][0];
    em = mdl[0][1];
    es = mdl[0][1] & mdl[0][2];
    n_chk++;
    if ({timing_rst_o, mode_3w_o, use_src2_o} !== {er, em, es}) begin
      n_bad++;
      $display("FAIL %s: ctrl actual=%b%b%b expected=%b%b%b", req,
               timing_rst_o, mode_3w_o, use_src2_o, er, em, es);
    end
  endtask

  initial begin : main
    reset_model();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (8) @(negedge clk);
    check_bank("R7 reset state");
    check_ctrl("R9 reset state");

    // R1 R2: every address, several data patterns
    for (int a = 0; a < NREG; a++) begin
      for (int p = 0; p < 4; p++) begin
        logic [7:0] d;
        d = 8'((a * 37 + p * 91 + 5) ^ (p[0] ? 8'hA5 : 8'h3C));
        send(mk(3'b011, 5'(a), d), 16);
        mdl[a] = d;
        check_bank("R1 write");
      end
    end

    // R5: every wrong header
    for (int h = 0; h < 8; h++) begin
      if (h != 3) begin
        send(mk(3'(h), 5'(h % NREG), 8'hFF ^ 8'(h)), 16);
        check_bank("R5 bad header ignored");
      end
    end

    // R6: addresses past the bank
    for (int a = NREG; a < 32; a++) begin
      send(mk(3'b011, 5'(a), 8'(a)), 16);
      check_bank("R6 out-of-range address");
    end

    // R3: short frames
    for (int n = 1; n < 16; n += 4) begin
      send(mk(3'b011, 5'd3, 8'h5A), n);
      check_bank("R3 short frame dropped");
    end
    send(mk(3'b011, 5'd3, 8'h5A), 15);
    check_bank("R3 fifteen edges dropped");

    // R4: extra clocks after 16
    send(mk(3'b011, 5'd4, 8'h12), 21);
    mdl[4] = 8'h12;
    check_bank("R4 extra edges ignored");

    // R9 R10: control bit combinations
    for (int c = 0; c < 8; c++) begin
      send(mk(3'b011, 5'd0, 8'(c)), 16);
      mdl[0] = 8'(c);
      check_bank("R9 soft reset keeps others");
      check_ctrl("R10 source select");
    end

    // R7: power-down restores defaults and blocks writes
    pdn_n = 1'b0;
    repeat (8) @(negedge clk);
    reset_model();
    check_bank("R7 power-down defaults");
    check_ctrl("R7 power-down ctrl");
    send(mk(3'b011, 5'd2, 8'h77), 16);
    check_bank("R7 write during power-down");
    pdn_n = 1'b1;
    repeat (8) @(negedge clk);
    send(mk(3'b011, 5'd2, 8'h77), 16);
    mdl[2] = 8'h77;
    check_bank("R7 write after power-down");

    // R8: master clock stopped
    mclk_en = 1'b0;
    repeat (120) @(negedge clk);
    send(mk(3'b011, 5'd5, 8'hC3), 16);
    check_bank("R8 write without mclk");
    mclk_en = 1'b1;
    repeat (20) @(negedge clk);
    send(mk(3'b011, 5'd5, 8'hC3), 16);
    mdl[5] = 8'hC3;
    check_bank("R8 write after mclk returns");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule